// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block gathers eight interrupt request lines into one interrupt line towards a host processor. Pending requests are held in a request register. Each line can be blocked through a mask register that the host writes. An in-service register records the levels the host is currently handling. A fixed-priority resolver gives line 0 the highest rank and line 7 the lowest. The interrupt line is raised only when the best unmasked pending request outranks every level already in service.

The host acknowledges with a one-cycle pulse. The winning level then moves into service, and the block returns a vector byte built from a host-supplied base and the level number. The block also drives a 3-bit ID naming that level, for expansion across several controllers. A non-specific end-of-interrupt pulse retires the highest-ranked level in service. One input chooses how the request lines are sensed: as levels, or as rising edges.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o, vec_valid_o, vector_o, cas_id_o, the mask, the request register and the in-service register are all zero.
- R2: With trig_edge_i = 0 (level sensing), the request register copies irq_req_i at each clock, so irq_o follows a request one cycle after the clock edge that samples it, and drops again once the request is removed.
- R3: With trig_edge_i = 1 (edge sensing), a request bit is set by a 0-to-1 change of its line seen between two clocks. It stays set after the line falls. A line held high is not latched a second time until it has gone low and risen again.
- R4: A request line whose mask bit is 1 never raises irq_o. mask_we_i loads mask_wdata_i into the mask at the clock edge. A request that is still pending interrupts once its mask bit is cleared.
- R5: Priority is fixed, with line 0 highest. When several unmasked requests are pending, the lowest index wins.
- R6: irq_o is 1 only when the winning request index is strictly lower than the lowest index set in the in-service register, or when nothing is in service.
- R7: When ack_i is 1 while irq_o is 1, at the next clock the winning level enters service and vector_o becomes {vec_base_i[4:0], level[2:0]}. vec_valid_o is then 1 for exactly that one cycle, and cas_id_o holds the level until the next accepted acknowledge.
- R8: ack_i while irq_o is 0 has no effect: vec_valid_o stays 0, and the vector, the ID and the in-service register are unchanged.
- R9: eoi_i clears the lowest-index set bit of the in-service register, which lets lower-ranked pending requests interrupt again.
- R10: In edge mode, an accepted acknowledge clears the winning request bit, unless a new rising edge on that line arrives in the same cycle. In level mode, the bit stays set for as long as the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 8 | Request lines, bit 0 highest priority |
| trig_edge_i | input | 1 | 1 = rising-edge sensing, 0 = level sensing |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | New mask value, 1 blocks the line |
| vec_base_i | input | 5 | Upper five bits of the vector |
| ack_i | input | 1 | Host acknowledge pulse |
| eoi_i | input | 1 | Non-specific end-of-interrupt pulse |
| irq_o | output | 1 | Interrupt to host |
| vector_o | output | 8 | Vector of the last accepted acknowledge |
| vec_valid_o | output | 1 | One-cycle pulse marking a fresh vector |
| cas_id_o | output | 3 | Level of the last accepted acknowledge |

## Verification
Directed patterns run first, one per behaviour:
- Two simultaneous level requests show that the lower index wins.
- A lower-ranked request that arrives while a higher one is in service stays silent, which tells in-service blocking apart from plain masking.
- A higher-ranked arrival nests on top of the level in service.
- Two end-of-interrupt pulses retire the levels in order, and the held request then comes through.
- A short pulse in edge mode shows that the request is latched, and a held line shows that it is not latched twice.
- An acknowledge with every line masked shows that it is ignored.

A long pseudo-random run follows, mixing requests, acknowledges, end-of-interrupt pulses, mask writes and mode changes. It is compared every cycle against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg
  import irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  trig_e        trig_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q, irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= req_i;
      if (trig_i == TRIG_EDGE) irr_q <= (req_i & ~prev_q) | (irr_q & ~clr_i);
      else                     irr_q <= req_i;
    end
  end

  assign irr_o = irr_q;

  // R3: a line held high is never re-latched
  assert_no_relatch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == TRIG_EDGE && (clr_i & prev_q & req_i) == clr_i && clr_i != '0)
      |=> (irr_q & $past(clr_i)) == '0);
endmodule

// File: rtl/irq_service.sv
module irq_service #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         take_i,
  input  logic [W-1:0] take_idx_i,
  input  logic         eoi_i,
  output logic         top_any_o,
  output logic [W-1:0] top_idx_o
);
  logic [N-1:0] isr_q, eoi_clr, take_set;

  irq_prio_enc #(.N(N)) u_top (.vec_i(isr_q), .any_o(top_any_o), .idx_o(top_idx_o));

  always_comb begin
    eoi_clr  = '0;
    take_set = '0;
    if (eoi_i && top_any_o) eoi_clr[top_idx_o] = 1'b1;
    if (take_i)             take_set[take_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~eoi_clr) | take_set;
  end

  assert_eoi_one_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q != '0 && !take_i) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8,
  localparam int LVL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic              trig_edge_i,
  input  logic              mask_we_i,
  input  logic [N_IRQ-1:0]  mask_wdata_i,
  input  logic [BASE_W-1:0] vec_base_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              vec_valid_o,
  output logic [LVL_W-1:0]  cas_id_o
);
  logic [N_IRQ-1:0] irr, mask_q, pend, clr;
  logic             pend_any, isr_any, take;
  logic [LVL_W-1:0] win_idx, isr_idx;
  logic [VEC_W-1:0] vec_q;
  logic             vv_q;
  logic [LVL_W-1:0] cas_q;
  trig_e            trig;

  assign trig = trig_e'(trig_edge_i);
  assign pend = irr & ~mask_q;

  irq_req_reg #(.N(N_IRQ)) u_req (
    .clk_i, .rst_ni, .req_i(irq_req_i), .trig_i(trig), .clr_i(clr), .irr_o(irr));

  irq_prio_enc #(.N(N_IRQ)) u_win (.vec_i(pend), .any_o(pend_any), .idx_o(win_idx));

  irq_service #(.N(N_IRQ)) u_isr (
    .clk_i, .rst_ni, .take_i(take), .take_idx_i(win_idx), .eoi_i,
    .top_any_o(isr_any), .top_idx_o(isr_idx));

  assign irq_o = pend_any && (!isr_any || win_idx < isr_idx);
  assign take  = ack_i && irq_o;

  always_comb begin
    clr = '0;
    if (take) clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      vec_q  <= '0;
      vv_q   <= 1'b0;
      cas_q  <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      vv_q <= take;
      if (take) begin
        vec_q <= {vec_base_i, win_idx};
        cas_q <= win_idx;
      end
    end
  end

  assign vector_o    = vec_q;
  assign vec_valid_o = vv_q;
  assign cas_id_o    = cas_q;

  assert_ack_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> vec_valid_o && vector_o == {$past(vec_base_i), $past(win_idx)});
  assert_ack_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> !vec_valid_o && $stable(vector_o) && $stable(cas_id_o));
  assert_full_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask_wd = '0;
  logic       trig_edge = 1'b0, mask_we = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [4:0] base = 5'b10100;
  logic       irq, vv;
  logic [7:0] vec;
  logic [2:0] cas;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0] m_irr = '0, m_isr = '0, m_prev = '0, m_mask = '0, m_vec = '0;
  logic       m_vv = 1'b0;
  logic [2:0] m_cas = '0;

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .trig_edge_i(trig_edge),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .vec_base_i(base),
    .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vector_o(vec),
    .vec_valid_o(vv), .cas_id_o(cas));

  function automatic int first_set(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic m_irq();
    int w = first_set(m_irr & ~m_mask);
    return (w < 8) && (w < first_set(m_isr));
  endfunction

  task automatic model_tick();
    int  w    = first_set(m_irr & ~m_mask);
    int  t    = first_set(m_isr);
    logic take = ack && m_irq();
    logic [7:0] nirr;
    for (int i = 0; i < 8; i++) begin
      if (trig_edge) begin
        if (req[i] && !m_prev[i])   nirr[i] = 1'b1;
        else if (take && i == w)    nirr[i] = 1'b0;
        else                        nirr[i] = m_irr[i];
      end else nirr[i] = req[i];
    end
    if (eoi && t < 8) m_isr[t] = 1'b0;
    if (take) begin
      m_isr[w] = 1'b1;
      m_vec = {base, 3'(w)};
      m_cas = 3'(w);
    end
    m_vv = take;
    if (mask_we) m_mask = mask_wd;
    m_irr = nirr;
    m_prev = req;
  endtask

  task automatic check(string t, logic [7:0] act, logic [7:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_tick();
    check(tag, {7'd0, irq}, {7'd0, m_irq()}, "irq_o");
    check(tag, {7'd0, vv}, {7'd0, m_vv}, "vec_valid_o");
    check(tag, vec, m_vec, "vector_o");
    check(tag, {5'd0, cas}, {5'd0, m_cas}, "cas_id_o");
  endtask

  task automatic pulse_ack();  ack = 1'b1; step(); ack = 1'b0; endtask
  task automatic pulse_eoi();  eoi = 1'b1; step(); eoi = 1'b0; endtask
  task automatic write_mask(logic [7:0] m); mask_wd = m; mask_we = 1'b1; step(); mask_we = 1'b0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", {7'd0, irq}, 8'd0, "irq_o in reset");
    check("R1", {7'd0, vv}, 8'd0, "vec_valid_o in reset");
    check("R1", vec, 8'd0, "vector_o in reset");
    check("R1", {5'd0, cas}, 8'd0, "cas_id_o in reset");
    rst_n = 1'b1;
    step();

    // level sensing
    tag = "R2";
    req = 8'h08; step();
    check("R2", {7'd0, irq}, 8'd1, "irq after level request");
    req = 8'h00; step();
    check("R2", {7'd0, irq}, 8'd0, "irq after request removed");

    // priority and vector
    tag = "R5";
    req = 8'h24; step();
    pulse_ack();
    check("R5", vec, 8'hA2, "winner vector");
    check("R7", {7'd0, vv}, 8'd1, "valid pulse");
    check("R7", {5'd0, cas}, 8'd2, "cascade id");
    step();
    check("R7", {7'd0, vv}, 8'd0, "valid one cycle only");

    // in-service blocking and nesting
    tag = "R6";
    check("R6", {7'd0, irq}, 8'd0, "IR5 blocked by IR2 in service");
    req = 8'h26; step();
    check("R6", {7'd0, irq}, 8'd1, "IR1 outranks IR2");
    pulse_ack();
    check("R6", vec, 8'hA1, "nested vector");
    tag = "R10";
    check("R10", {7'd0, irq}, 8'd0, "level request still held but in service");
    req = 8'h20; step();

    // end of interrupt
    tag = "R9";
    pulse_eoi();
    check("R9", {7'd0, irq}, 8'd0, "IR2 still blocks IR5");
    pulse_eoi();
    check("R9", {7'd0, irq}, 8'd1, "IR5 after both retired");

    // mask and ignored acknowledge
    tag = "R4";
    write_mask(8'h20);
    check("R4", {7'd0, irq}, 8'd0, "masked IR5");
    tag = "R8";
    pulse_ack();
    check("R8", {7'd0, vv}, 8'd0, "ack without irq ignored");
    check("R8", vec, 8'hA1, "vector unchanged");
    tag = "R4";
    write_mask(8'h00);
    check("R4", {7'd0, irq}, 8'd1, "unmasked IR5 interrupts, nothing in service");
    req = 8'h00; step();

    // edge sensing
    tag = "R3";
    trig_edge = 1'b1;
    step();
    req = 8'h10; step();
    req = 8'h00; step();
    check("R3", {7'd0, irq}, 8'd1, "short pulse latched");
    pulse_ack();
    check("R3", vec, 8'hA4, "edge vector");
    tag = "R10";
    pulse_eoi();
    check("R10", {7'd0, irq}, 8'd0, "edge request cleared by ack");
    tag = "R3";
    req = 8'h40; step(); step();
    pulse_ack();
    pulse_eoi();
    step();
    check("R3", {7'd0, irq}, 8'd0, "held line not re-latched");
    req = 8'h00; step();
    req = 8'h40; step();
    check("R3", {7'd0, irq}, 8'd1, "re-latched after low");
    pulse_ack(); pulse_eoi();
    req = 8'h00; step();

    // mixed pseudo-random traffic
    tag = "R5";
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req  = lfsr[7:0] & lfsr[15:8];
      ack  = lfsr[3] & lfsr[9];
      eoi  = lfsr[5] & lfsr[11] & lfsr[1];
      mask_we = (lfsr[15:12] == 4'hF);
      mask_wd = lfsr[10:3];
      base = lfsr[14:10];
      if (n % 500 == 0) trig_edge = ~trig_edge;
      step();
    end
    ack = 1'b0; eoi = 1'b0; mask_we = 1'b0;
    step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule